// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Idle Timeout

This block holds received characters between a UART deserializer and the register interface that software reads. Incoming bytes arrive one per cycle on a push port. In local loopback, the same port can be fed from the transmit register path instead of the deserializer. Software drains the queue through a pop request, and each pop returns one byte a cycle later. The queue keeps bytes in arrival order and holds up to 16 of them. It reports empty, full and a programmable fill-level flag. It also sends two one-cycle event pulses to a separate interrupt block: one when a byte is lost to overflow, and one when the line has gone quiet.

A control write sets the receive enable and disable bits and can also carry a one-shot flush command. The queue accepts pushes and pops only while enable is set and disable is clear. The idle timer counts character-time ticks supplied from outside. It restarts on every accepted byte and fires once after four quiet character times. This lets software pick up a short message that never reaches the fill level.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `trig`=0, both event pulses are 0 and `pop_data`=0. The receiver starts disabled (enable=0, disable=1) and the fill level register holds 32.
- R2: Bytes are popped in the order they were accepted. `full` is 1 exactly when 16 bytes are held and `empty` is 1 exactly when none are held; the two are never 1 together.
- R3: A push while 16 bytes are held and no pop is taken in the same cycle drops the byte and raises `ovf_pulse` for one cycle. The stored bytes are left unchanged.
- R4: `ctl_wdata` bit 0 is enable and bit 1 is disable. Pushes and pops take effect only while enable=1 and disable=0. An ignored push is lost and causes no overflow. An ignored pop returns 0 and leaves the contents in place.
- R5: A pop while the queue is empty returns 0 and `empty` stays 1.
- R6: `trig` is set by an accepted push after which the count is at least the fill level. It is cleared by an effective pop after which the count is below the level. The level is 6 bits wide, so with the reset value of 32 the flag never rises.
- R7: Each accepted push restarts the idle timer. The `tmo_pulse` output is 1 for exactly one cycle, right after the fourth `char_tick` that follows the last accepted push. A further push resets the tick count to zero.
- R8: A control write with bit 2 set empties the queue and sets `empty`=1, `full`=0, `trig`=0. The bit is not stored, so later control writes without it leave the contents intact.
- R9: When a push and a pop take effect in the same cycle, both are performed and the count is unchanged. This also holds when the queue is full, in which case there is no overflow.
- R10: `empty`, `full`, `trig`, `ovf_pulse` and `pop_data` all change on the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control word: bit0 enable, bit1 disable, bit2 flush |
| lvl_wr | input | 1 | Fill level write strobe |
| lvl_wdata | input | 6 | New fill level |
| push_valid | input | 1 | Byte offered from the deserializer or loopback path |
| push_data | input | 8 | Offered byte |
| pop_req | input | 1 | Read request from the register interface |
| pop_data | output | 8 | Byte returned by the last pop, 0 if none was available |
| char_tick | input | 1 | One pulse per character time |
| empty | output | 1 | No bytes held |
| full | output | 1 | 16 bytes held |
| trig | output | 1 | Fill-level flag |
| ovf_pulse | output | 1 | One-cycle overflow event |
| tmo_pulse | output | 1 | One-cycle idle-timeout event |

## Verification
Every flag, the overflow pulse and the popped byte are due one clock edge after the cycle that drives the request. The bench drives inputs on the falling edge and samples on the next falling edge, half a cycle after that register stage. The timeout pulse is due on the edge that samples the fourth tick, so it is checked right after that tick and again one cycle later, when it must have dropped. Popped bytes are queued as expectations when each pop is driven. A monitor then compares them against `pop_data` on the falling edge that follows the sampling edge.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;
  // control word layout, low bit first: enable, disable, flush
  typedef struct packed {
    logic flush;
    logic dis;
    logic en;
  } rxq_ctl_t;
endpackage

// File: rtl/uart_rx_queue_ram.sv
module uart_rx_queue_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  // read-first single-clock dual-port style, suits block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/uart_rx_queue_idle.sv
module uart_rx_queue_idle #(
  parameter int TMO_CHARS = 4,
  localparam int TW       = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic fire
);
  logic          armed;
  logic [TW-1:0] n;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      n     <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (restart) begin
        armed <= 1'b1;
        n     <= '0;
      end else if (armed && tick) begin
        if (n == TW'(TMO_CHARS - 1)) begin
          armed <= 1'b0;
          fire  <= 1'b1;
        end else begin
          n <= n + TW'(1);
        end
      end
    end
  end

  p_fire_single_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  p_fire_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(tick) && !$past(restart));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_queue_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int LVL_W     = 6,
  parameter int LVL_RST   = 32,
  parameter int TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_wdata,
  input  logic             lvl_wr,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic             pop_req,
  output logic [DW-1:0]    pop_data,
  input  logic             char_tick,
  output logic             empty,
  output logic             full,
  output logic             trig,
  output logic             ovf_pulse,
  output logic             tmo_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rxq_ctl_t       ctl_in;
  logic           en_q, dis_q, active;
  logic [LVL_W-1:0] lvl_q;
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  cnt, cnt_nx;
  logic           flush, pop_en, pop_take, push_ok, ovf_nx, at_full;
  logic           sel_q;
  logic [DW-1:0]  rd_q;

  assign ctl_in   = rxq_ctl_t'(ctl_wdata);
  assign flush    = ctl_wr && ctl_in.flush;
  assign active   = en_q && !dis_q;
  assign at_full  = (cnt == CW'(DEPTH));
  assign pop_en   = pop_req && active;
  assign pop_take = pop_en && (cnt != '0) && !flush;
  assign push_ok  = push_valid && active && !flush && (!at_full || pop_take);
  assign ovf_nx   = push_valid && active && !flush && at_full && !pop_en;
  assign rd_ptr   = wr_ptr - cnt[AW-1:0];

  always_comb begin
    if (flush) cnt_nx = '0;
    else begin
      case ({push_ok, pop_take})
        2'b10:   cnt_nx = cnt + CW'(1);
        2'b01:   cnt_nx = cnt - CW'(1);
        default: cnt_nx = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      dis_q     <= 1'b1;
      lvl_q     <= LVL_W'(LVL_RST);
      wr_ptr    <= '0;
      cnt       <= '0;
      empty     <= 1'b1;
      full      <= 1'b0;
      trig      <= 1'b0;
      ovf_pulse <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q  <= ctl_in.en;
        dis_q <= ctl_in.dis;
      end
      if (lvl_wr) lvl_q <= lvl_wdata;
      if (flush) wr_ptr <= '0;
      else if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      cnt       <= cnt_nx;
      empty     <= (cnt_nx == '0);
      full      <= (cnt_nx == CW'(DEPTH));
      ovf_pulse <= ovf_nx;
      if (flush) trig <= 1'b0;
      else if (push_ok && (LVL_W'(cnt_nx) >= lvl_q)) trig <= 1'b1;
      else if (pop_en && (LVL_W'(cnt_nx) < lvl_q)) trig <= 1'b0;
      if (pop_req) sel_q <= pop_take;
    end
  end

  uart_rx_queue_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk (clk),
    .we  (push_ok),
    .wa  (wr_ptr),
    .wd  (push_data),
    .re  (pop_req),
    .ra  (rd_ptr),
    .rq  (rd_q)
  );

  assign pop_data = sel_q ? rd_q : '0;

  uart_rx_queue_idle #(.TMO_CHARS(TMO_CHARS)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .restart (push_ok),
    .tick    (char_tick),
    .fire    (tmo_pulse)
  );

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  p_ovf_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(full));
  p_ovf_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> cnt == $past(cnt));
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!active && !ctl_wr) |=> $stable(cnt));
  p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && active && empty && !push_valid && !ctl_wr) |=> (pop_data == '0) && empty);
  p_both_keep_count_r9: assert property (@(posedge clk) disable iff (rst)
    (push_valid && pop_req && active && !empty && !ctl_wr) |=> $stable(cnt) && !ovf_pulse);
endmodule

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic       lvl_wr = 1'b0;
  logic [5:0] lvl_wdata = '0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop_req = 1'b0;
  logic [7:0] pop_data;
  logic       char_tick = 1'b0;
  logic       empty, full, trig, ovf_pulse, tmo_pulse;

  int nchk = 0, nfail = 0, cyc = 0;
  bit m_en = 0, m_dis = 1, m_trig = 0, done = 0;
  int m_lvl = 32;
  byte unsigned mq[$];
  byte unsigned exp_q[$];
  logic pop_seen = 1'b0;

  always #10 clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .char_tick(char_tick), .empty(empty), .full(full), .trig(trig),
    .ovf_pulse(ovf_pulse), .tmo_pulse(tmo_pulse)
  );

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each popped byte with the scoreboard (R2, R4, R5, R10)
  always @(posedge clk) pop_seen <= pop_req;
  always @(negedge clk) begin
    if (pop_seen && !rst) begin
      byte unsigned e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      check("R2/R10 pop_data", int'(pop_data), int'(e));
    end
  end

  task automatic flags(string req);
    check({req, " empty"}, int'(empty), int'(mq.size() == 0));
    check({req, " full"}, int'(full), int'(mq.size() == 16));
    check({req, " trig R6"}, int'(trig), int'(m_trig));
  endtask

  // driver: one cycle of push/pop, updating the scoreboard model
  task automatic step(bit ps, byte unsigned d, bit pp);
    int sz = mq.size();
    bit act = m_en && !m_dis;
    bit pe = pp && act;
    bit take = pe && sz > 0;
    bit acc = ps && act && (sz < 16 || take);
    bit eovf = ps && act && sz == 16 && !pe;
    if (pp) exp_q.push_back(take ? mq[0] : 8'h00);
    if (take) void'(mq.pop_front());
    if (acc) mq.push_back(d);
    if (acc && mq.size() >= m_lvl) m_trig = 1;
    else if (pe && mq.size() < m_lvl) m_trig = 0;
    push_valid = ps; push_data = d; pop_req = pp;
    @(negedge clk);
    push_valid = 0; pop_req = 0;
    check("R3 ovf_pulse", int'(ovf_pulse), int'(eovf));
  endtask

  task automatic ctl(bit en, bit dis, bit fl);
    ctl_wr = 1; ctl_wdata = {fl, dis, en};
    m_en = en; m_dis = dis;
    if (fl) begin mq.delete(); m_trig = 0; end
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic set_lvl(int l);
    lvl_wr = 1; lvl_wdata = 6'(l); m_lvl = l;
    @(negedge clk);
    lvl_wr = 0;
  endtask

  task automatic tick(int exp_fire);
    char_tick = 1;
    @(negedge clk);
    char_tick = 0;
    check("R7 tmo_pulse", int'(tmo_pulse), exp_fire);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 trig", int'(trig), 0);
    check("R1 ovf", int'(ovf_pulse), 0);
    check("R1 tmo", int'(tmo_pulse), 0);
    check("R1 pop_data", int'(pop_data), 0);
    // R4 disabled after reset: push ignored, pop returns zero
    step(1, 8'hA5, 0);
    flags("R4 disabled push");
    step(0, 0, 1);
    ctl(1, 0, 0);
    step(0, 0, 1);
    flags("R4 enabled, still empty");
    // R2 order with a few bytes
    for (int i = 0; i < 3; i++) step(1, 8'(8'h10 + i), 0);
    flags("R2 three held");
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    flags("R2 drained");
    // R5 pop while empty
    step(0, 0, 1);
    flags("R5 empty pop");
    // R2/R3 fill to depth, then overflow
    for (int i = 0; i < 16; i++) step(1, 8'(8'h40 + i), 0);
    flags("R2 full at 16, R6 level 32 no trig");
    step(1, 8'hEE, 0);
    flags("R3 after overflow");
    // R9 push and pop together while full
    step(1, 8'h77, 1);
    flags("R9 full both");
    for (int i = 0; i < 16; i++) step(0, 0, 1);
    flags("R3/R9 drained");
    // R4 disable keeps contents, ignored pop returns zero
    step(1, 8'h3C, 0);
    ctl(1, 1, 0);
    step(0, 0, 1);
    step(1, 8'h99, 0);
    flags("R4 while disabled");
    ctl(1, 0, 0);
    step(0, 0, 1);
    flags("R4 re-enabled");
    // R8 flush, and flush bit not retained
    for (int i = 0; i < 5; i++) step(1, 8'(8'h60 + i), 0);
    ctl(1, 0, 1);
    flags("R8 after flush");
    step(1, 8'h21, 0);
    ctl(1, 0, 0);
    flags("R8 flush not retained");
    step(0, 0, 1);
    // R6 trigger at level 4
    set_lvl(4);
    for (int i = 0; i < 3; i++) step(1, 8'(i), 0);
    flags("R6 below level");
    step(1, 8'h03, 0);
    flags("R6 at level");
    step(0, 0, 1);
    flags("R6 below after pop");
    step(1, 8'h04, 1);
    flags("R9 both keeps count");
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    // R7 idle timeout
    step(1, 8'h55, 0);
    for (int i = 0; i < 3; i++) tick(0);
    step(1, 8'h56, 0);
    for (int i = 0; i < 3; i++) tick(0);
    tick(1);
    @(negedge clk);
    check("R7 pulse one cycle", int'(tmo_pulse), 0);
    tick(0);
    for (int i = 0; i < 2; i++) step(0, 0, 1);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule